// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the SECDED checker of a memory controller and keeps a record of the first ECC event it sees. The checker pulses a single-bit (corrected) strobe or a multi-bit (uncorrectable) strobe for one cycle and presents the failing address and its 8-bit syndrome in that same cycle. The block latches the upper address bits, the syndrome and a flag that gives the error's kind. It then holds that record until software clears it, and events that arrive in the meantime are dropped.

Software sees one packed 32-bit status word and writes that same word back. Three bits of the word are plain read/write controls. The first turns off write-back of corrected data, which the block reports to the scrub path as a scrub-enable level. The second lets a logged single-bit error raise a non-maskable-interrupt request. The third lets a logged multi-bit error raise a bus-error request. The two error flags are write-1-to-clear. Capture starts again only once both flags are clear.

Top module: `ecc_err_capture`

## Requirements
- R1: After synchronous reset the status word reads 0, `nmi_req` and `berr_req` are 0 and `scrub_en` is 1.
- R2: When both flags are clear, a cycle with `sbe_stb`=1 and `mbe_stb`=0 sets bit 0 at the next edge. At that edge bits 30:12 take `err_addr[31:13]` and bits 11:4 take `err_syn`.
- R3: When both flags are clear, a cycle with `mbe_stb`=1 sets bit 1 at the next edge and loads the address and syndrome fields in the same way as R2.
- R4: When both flags are clear and both strobes arrive in the same cycle, only bit 1 is set and bit 0 stays 0.
- R5: While bit 0 or bit 1 is set, strobes change neither the address, the syndrome nor the flag bits.
- R6: A write with bit 0 or bit 1 set to 1 clears that flag at the next edge. A 0 in either bit leaves that flag as it was.
- R7: Clearing only the flag that is already 0 does not re-arm capture. The logged record stays in place and new strobes are still dropped.
- R8: Every write loads bits 31, 3 and 2 of the status word from the write data. Without a write they hold their value.
- R9: `scrub_en` is the inverse of bit 31 and changes in the same cycle as bit 31.
- R10: `nmi_req` is 1 in the cycle after one in which bit 0 and bit 2 are both 1, and is 0 otherwise. It is a level.
- R11: `berr_req` is 1 in the cycle after one in which bit 1 and bit 3 are both 1, and is 0 otherwise. It is a level.
- R12: If a write clears the set flag in the same cycle as a strobe, the flag clears and that strobe is dropped, because the log was not empty at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_stb | input | 1 | Single-bit (corrected) error strobe |
| mbe_stb | input | 1 | Multi-bit (uncorrectable) error strobe |
| err_addr | input | ADDR_W | Failing address, valid with a strobe |
| err_syn | input | 8 | ECC syndrome, valid with a strobe |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| status_word | output | 32 | Packed status word |
| nmi_req | output | 1 | Non-maskable-interrupt request level |
| berr_req | output | 1 | Bus-error request level |
| scrub_en | output | 1 | Corrected-data write-back allowed |

## Verification
The bench targets the cases where ordering decides the outcome. Both strobes in one cycle must log only the multi-bit flag, and a design that let the single-bit path win, or set both flags, would show bit 0 high. A strobe that arrives while a record is held, or in the same cycle as the write that clears it, must be dropped; a design that overwrote the record would change the address and syndrome fields. A write that clears only the flag already at 0 must leave the record armed against new capture. The request outputs are compared one cycle after their flag and enable change, so a request that ignored its enable, or kept the wrong latency, would miscompare.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int WORD_W      = 32;
  localparam int SBE_B       = 0;
  localparam int MBE_B       = 1;
  localparam int NMI_EN_B    = 2;
  localparam int BERR_EN_B   = 3;
  localparam int SYN_LO      = 4;
  localparam int SYN_W       = 8;
  localparam int ADR_LO      = 12;
  localparam int ADR_KEEP    = 19;
  localparam int SCRUB_DIS_B = 31;

  typedef struct packed {
    logic scrub_dis;
    logic berr_en;
    logic nmi_en;
  } ctrl_t;
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output logic              scrub_en_q
);
  logic unused_ctrl;
  assign unused_ctrl = ^{wr_data[SCRUB_DIS_B-1:BERR_EN_B+1], wr_data[MBE_B:SBE_B]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      scrub_en_q <= 1'b1;
    end else if (wr_en) begin
      ctrl_q.scrub_dis <= wr_data[SCRUB_DIS_B];
      ctrl_q.berr_en   <= wr_data[BERR_EN_B];
      ctrl_q.nmi_en    <= wr_data[NMI_EN_B];
      scrub_en_q       <= ~wr_data[SCRUB_DIS_B];
    end
  end

  // R9: the scrub level and the stored disable bit never disagree
  a_r9_scrub_inverse: assert property (@(posedge clk) disable iff (rst)
    scrub_en_q != ctrl_q.scrub_dis);

  // R8: enables hold when no write occurred
  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log
  import ecc_cap_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sbe_stb,
  input  logic                mbe_stb,
  input  logic [ADR_KEEP-1:0] addr_top,
  input  logic [SYN_W-1:0]    syn_in,
  input  logic                clr_sbe,
  input  logic                clr_mbe,
  output logic                sbe_q,
  output logic                mbe_q,
  output logic [ADR_KEEP-1:0] addr_q,
  output logic [SYN_W-1:0]    syn_q
);
  logic empty;
  logic take;

  assign empty = ~sbe_q & ~mbe_q;
  assign take  = empty & (sbe_stb | mbe_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
      addr_q <= '0;
      syn_q  <= '0;
    end else if (take) begin
      mbe_q  <= mbe_stb;
      sbe_q  <= ~mbe_stb;
      addr_q <= addr_top;
      syn_q  <= syn_in;
    end else begin
      if (clr_sbe) sbe_q <= 1'b0;
      if (clr_mbe) mbe_q <= 1'b0;
    end
  end

  // R4: the log never holds both kinds at once
  a_r4_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sbe_q, mbe_q}));

  // R3/R4: a multi-bit strobe into an empty log always sets the multi-bit flag
  a_r3_mbe_capture: assert property (@(posedge clk) disable iff (rst)
    (empty && mbe_stb) |=> (mbe_q && !sbe_q));

  // R5: a held record keeps its fields
  a_r5_hold_fields: assert property (@(posedge clk) disable iff (rst)
    !empty |=> ($stable(addr_q) && $stable(syn_q)));

  // R12: a full clear while held leaves the log empty, strobes notwithstanding
  a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (!empty && clr_sbe && clr_mbe) |=> (!sbe_q && !mbe_q));
endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq (
  input  logic clk,
  input  logic rst,
  input  logic sbe_f,
  input  logic mbe_f,
  input  logic nmi_en,
  input  logic berr_en,
  output logic nmi_req_q,
  output logic berr_req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_req_q  <= 1'b0;
      berr_req_q <= 1'b0;
    end else begin
      nmi_req_q  <= sbe_f & nmi_en;
      berr_req_q <= mbe_f & berr_en;
    end
  end

  // R10: an enabled single-bit record raises the request a cycle later
  a_r10_nmi_rise: assert property (@(posedge clk) disable iff (rst)
    (sbe_f && nmi_en) |=> nmi_req_q);
  a_r10_nmi_quiet: assert property (@(posedge clk) disable iff (rst)
    !sbe_f |=> !nmi_req_q);

  // R11: an enabled multi-bit record raises the bus-error request a cycle later
  a_r11_berr_rise: assert property (@(posedge clk) disable iff (rst)
    (mbe_f && berr_en) |=> berr_req_q);
  a_r11_berr_quiet: assert property (@(posedge clk) disable iff (rst)
    !berr_en |=> !berr_req_q);
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_stb,
  input  logic              mbe_stb,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] status_word,
  output logic              nmi_req,
  output logic              berr_req,
  output logic              scrub_en
);
  localparam int ADR_SHIFT = ADDR_W - ADR_KEEP;

  ctrl_t               ctrl_q;
  logic                sbe_f, mbe_f;
  logic [ADR_KEEP-1:0] addr_top, addr_q;
  logic [SYN_W-1:0]    syn_q;
  logic                clr_sbe, clr_mbe;

  generate
    if (ADR_SHIFT > 0) begin : g_trim
      logic unused_low;
      assign unused_low = ^err_addr[ADR_SHIFT-1:0];
      assign addr_top   = err_addr[ADDR_W-1:ADR_SHIFT];
    end else begin : g_full
      assign addr_top = err_addr[ADR_KEEP-1:0];
    end
  endgenerate

  assign clr_sbe = reg_wr & reg_wdata[SBE_B];
  assign clr_mbe = reg_wr & reg_wdata[MBE_B];

  ecc_cap_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr),
    .wr_data    (reg_wdata),
    .ctrl_q     (ctrl_q),
    .scrub_en_q (scrub_en)
  );

  ecc_cap_log u_log (
    .clk      (clk),
    .rst      (rst),
    .sbe_stb  (sbe_stb),
    .mbe_stb  (mbe_stb),
    .addr_top (addr_top),
    .syn_in   (err_syn),
    .clr_sbe  (clr_sbe),
    .clr_mbe  (clr_mbe),
    .sbe_q    (sbe_f),
    .mbe_q    (mbe_f),
    .addr_q   (addr_q),
    .syn_q    (syn_q)
  );

  ecc_cap_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .sbe_f      (sbe_f),
    .mbe_f      (mbe_f),
    .nmi_en     (ctrl_q.nmi_en),
    .berr_en    (ctrl_q.berr_en),
    .nmi_req_q  (nmi_req),
    .berr_req_q (berr_req)
  );

  assign status_word = {ctrl_q.scrub_dis, addr_q, syn_q,
                        ctrl_q.berr_en, ctrl_q.nmi_en, mbe_f, sbe_f};

  // R7: clearing only the already-clear flag leaves a held single-bit record
  a_r7_partial_clear: assert property (@(posedge clk) disable iff (rst)
    (sbe_f && !clr_sbe) |=> sbe_f);
endmodule

// File: tb/ecc_err_capture_tb_top.sv
module ecc_err_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        sbe_stb, mbe_stb, reg_wr;
  logic [31:0] err_addr, reg_wdata;
  logic [7:0]  err_syn;
  logic [31:0] status_word;
  logic        nmi_req, berr_req, scrub_en;

  int vectors = 0;
  int errors  = 0;

  logic        m_sbe, m_mbe, m_scr, m_nen, m_ben, m_nmi, m_berr;
  logic [18:0] m_addr;
  logic [7:0]  m_syn;

  always #5 clk = ~clk;

  ecc_err_capture #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .sbe_stb(sbe_stb), .mbe_stb(mbe_stb),
    .err_addr(err_addr), .err_syn(err_syn), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .status_word(status_word), .nmi_req(nmi_req),
    .berr_req(berr_req), .scrub_en(scrub_en)
  );

  function automatic logic [31:0] exp_word();
    return {m_scr, m_addr, m_syn, m_ben, m_nen, m_mbe, m_sbe};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "status", status_word, exp_word());
    chk(tag, "nmi_req", {31'd0, nmi_req}, {31'd0, m_nmi});
    chk(tag, "berr_req", {31'd0, berr_req}, {31'd0, m_berr});
    chk(tag, "scrub_en", {31'd0, scrub_en}, {31'd0, ~m_scr});
  endtask

  task automatic cycle(input string tag, input logic s, input logic m,
                       input logic [31:0] a, input logic [7:0] y,
                       input logic w, input logic [31:0] wd);
    logic empty;
    @(negedge clk);
    sbe_stb = s; mbe_stb = m; err_addr = a; err_syn = y;
    reg_wr = w; reg_wdata = wd;
    @(posedge clk);
    m_nmi  = m_sbe & m_nen;
    m_berr = m_mbe & m_ben;
    empty  = !m_sbe && !m_mbe;
    if (w) begin
      m_scr = wd[31]; m_ben = wd[3]; m_nen = wd[2];
    end
    if (empty && (s || m)) begin
      m_mbe = m; m_sbe = !m; m_addr = a[31:13]; m_syn = y;
    end else if (w) begin
      if (wd[0]) m_sbe = 1'b0;
      if (wd[1]) m_mbe = 1'b0;
    end
    @(negedge clk);
    sbe_stb = 1'b0; mbe_stb = 1'b0; reg_wr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    sbe_stb = 0; mbe_stb = 0; reg_wr = 0; err_addr = 0; err_syn = 0; reg_wdata = 0;
    rst = 1'b1;
    m_sbe = 0; m_mbe = 0; m_scr = 0; m_nen = 0; m_ben = 0;
    m_nmi = 0; m_berr = 0; m_addr = 0; m_syn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R2: single-bit capture
    cycle("R2", 1, 0, 32'hDEAD_B123, 8'h5A, 0, 0);
    // R5: strobes while held are dropped
    cycle("R5", 0, 1, 32'h1111_1111, 8'hC3, 0, 0);
    cycle("R5", 1, 0, 32'h2222_2222, 8'h3C, 0, 0);
    // R7: clear only the multi-bit flag, which is already 0, then strobe again
    cycle("R7", 0, 0, 0, 0, 1, 32'h0000_0002);
    cycle("R7", 1, 0, 32'h3333_3333, 8'h77, 0, 0);
    // R8 R10: enable interrupt without clearing, request follows a cycle later
    cycle("R8", 0, 0, 0, 0, 1, 32'h0000_0004);
    cycle("R10", 0, 0, 0, 0, 0, 0);
    // R6: zero bits do nothing, then clear the single-bit flag
    cycle("R6", 0, 0, 0, 0, 1, 32'h0000_0004);
    cycle("R6", 0, 0, 0, 0, 1, 32'h0000_0005);
    cycle("R10", 0, 0, 0, 0, 0, 0);
    // R4: both strobes into empty log
    cycle("R4", 1, 1, 32'hABCD_E000, 8'h81, 0, 0);
    // R11: enable bus error
    cycle("R11", 0, 0, 0, 0, 1, 32'h0000_0008);
    cycle("R11", 0, 0, 0, 0, 0, 0);
    // R12: clear both with a strobe in the same cycle
    cycle("R12", 1, 0, 32'h5555_5555, 8'h99, 1, 32'h0000_000B);
    cycle("R12", 0, 0, 0, 0, 0, 0);
    // R3: multi-bit capture alone
    cycle("R3", 0, 1, 32'h0F0F_F0F0, 8'hE7, 0, 0);
    // R9: scrub disable
    cycle("R9", 0, 0, 0, 0, 1, 32'h8000_0003);
    cycle("R9", 0, 0, 0, 0, 1, 32'h0000_0000);

    for (int i = 0; i < 3000; i++) begin
      logic s, m, w;
      logic [31:0] wd;
      s  = ($urandom % 4) == 0;
      m  = ($urandom % 8) == 0;
      w  = ($urandom % 6) == 0;
      wd = $urandom;
      if (w) cycle("R6", s, m, $urandom, 8'($urandom), w, wd);
      else if (!m_sbe && !m_mbe) cycle("R2", s, m, $urandom, 8'($urandom), w, wd);
      else cycle("R5", s, m, $urandom, 8'($urandom), w, wd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule